// File: doc/BRIEF.md
# PCI Interrupt Router with Routing Autodetect

This block merges the four legacy interrupt pins (INTA..INTD) of every PCI slot onto four level-sensitive system interrupt lines. Each slot contributes its pins to a small routing matrix. Each output is the logical OR of every pin level that lands on it. The routing is either a direct pin-to-line mapping or a rotated swizzle. The amount of rotation depends on a board-variant strap.

The choice between the two routings is made at run time. The block watches configuration-space write strobes. When a write targets the interrupt-line register of any device, the block inspects the written value to infer which routing the running software assumes. A sticky three-state mode register holds the result. It leaves its undecided state at most once per reset. A strap sets its reset value, so a known-good or known-legacy system can skip detection.

Top module: `irq_autoroute`

## Requirements
- R1: On reset the mode loads the mode strap: 0 = undecided, 1 = legacy, 2 = fixed. Strap value 3 loads undecided. The `mode` output carries that encoding and never shows 3.
- R2: Once the mode is legacy (1) or fixed (2), no configuration write changes it until the next reset.
- R3: A write is evaluated only when `cfg_wr` is high, `cfg_addr[7:0]` equals 0x3C and `alt_board` is 0. Every other write leaves the mode unchanged.
- R4: The slot of a write is the device number `cfg_addr[15:11]` modulo 4, that is `cfg_addr[12:11]`.
- R5: While undecided, a value of 27 written for slot 2 keeps the mode undecided. A value of 27 written for slot 0, 1 or 3 sets legacy.
- R6: While undecided, a value equal to slot+27 or to slot+91 sets legacy.
- R7: While undecided, any other value sets fixed.
- R8: In legacy mode, pin p of every slot (bit s*4+p of `int_lvl`, p = 0 for INTA) drives output line p.
- R9: In undecided or fixed mode, pin p of slot s drives line (s+p+2) mod 4 when `alt_board` is 0, and line (s+p+3) mod 4 when it is 1.
- R10: Each output line is the OR of all pin levels routed to it, combinationally from `int_lvl`.
- R11: The mode changes at the clock edge where the evaluated write strobe is high. The routing follows the new mode from that edge onward. Before that edge, routing uses the old mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| int_lvl | input | 16 | Pin levels, bit s*4+p = slot s pin p |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 24 | Configuration write address |
| cfg_wdata | input | 8 | Configuration write data (low byte) |
| alt_board | input | 1 | Board variant: 0 = rotation 2, 1 = rotation 3 and no detection |
| mode_strap | input | 2 | Reset value of the mode |
| irq_out | output | 4 | System interrupt lines |
| mode | output | 2 | Current routing mode |

## Verification
Several properties are checked on every cycle:
- A decided mode never moves.
- A write to another offset, or on the alternate board, leaves the mode alone.
- The encoding stays legal.
- A value outside both candidate ranges forces the fixed mode.
- In legacy mode each line equals the OR of its pin column.

Some behaviours can only be shown by the bench's directed scenarios:
- The exact slot-2 exception.
- The slot taken from the device number modulo 4.
- The rotation amount on each variant.
- The one-edge timing of the mode switch against the routing.

// File: rtl/irq_autoroute_pkg.sv
package irq_autoroute_pkg;

  localparam int LINE_W = 8;
  localparam int PINS   = 4;

  typedef enum logic [1:0] {
    MODE_ASSUME = 2'd0,
    MODE_BROKEN = 2'd1,
    MODE_FORCE  = 2'd2
  } route_mode_e;

  // Strap decode: the unused code 3 falls back to undecided.
  function automatic route_mode_e strap_to_mode(input logic [1:0] strap);
    case (strap)
      2'd1:    return MODE_BROKEN;
      2'd2:    return MODE_FORCE;
      default: return MODE_ASSUME;
    endcase
  endfunction

  // Verdict for a value written to a slot's interrupt-line register.
  function automatic route_mode_e judge_line(input logic [1:0]        slot,
                                             input logic [LINE_W-1:0] val,
                                             input logic [LINE_W-1:0] base,
                                             input logic [LINE_W-1:0] hi_ofs);
    logic [LINE_W-1:0] own_lo;
    logic [LINE_W-1:0] own_hi;
    own_lo = base + LINE_W'(slot);
    own_hi = own_lo + hi_ofs;
    if (val == base)
      return (slot == 2'd2) ? MODE_ASSUME : MODE_BROKEN;
    else if (val == own_lo || val == own_hi)
      return MODE_BROKEN;
    else
      return MODE_FORCE;
  endfunction

  // Destination line of one device pin.
  function automatic logic [1:0] route_idx(input logic [1:0] slot,
                                           input logic [1:0] pin,
                                           input logic       alt,
                                           input logic       legacy);
    logic [1:0] rot;
    rot = alt ? 2'd3 : 2'd2;
    return legacy ? pin : (slot + pin + rot);
  endfunction

endpackage

// File: rtl/irq_line_snoop.sv
module irq_line_snoop
  import irq_autoroute_pkg::*;
#(
  parameter int              ADDR_W      = 24,
  parameter logic [7:0]      LINE_OFS    = 8'h3C,
  parameter logic [LINE_W-1:0] LEGACY_BASE = 8'd27,
  parameter logic [LINE_W-1:0] HI_OFS      = 8'd64
) (
  input  logic              cfg_wr,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [LINE_W-1:0] cfg_wdata,
  input  logic              alt_board,
  output logic              hit,
  output route_mode_e       verdict
);

  localparam int DEV_LSB = 11;

  logic [1:0] slot;
  logic       unused_addr;

  assign slot    = cfg_addr[DEV_LSB+1:DEV_LSB];
  assign hit     = cfg_wr && !alt_board && (cfg_addr[7:0] == LINE_OFS);
  assign verdict = judge_line(slot, cfg_wdata, LEGACY_BASE, HI_OFS);

  assign unused_addr = ^{cfg_addr[ADDR_W-1:DEV_LSB+2], cfg_addr[DEV_LSB-1:8]};

endmodule

// File: rtl/irq_mode_reg.sv
module irq_mode_reg
  import irq_autoroute_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  strap,
  input  logic        hit,
  input  route_mode_e verdict,
  output route_mode_e mode_q,
  output logic        decide
);

  assign decide = hit && (mode_q == MODE_ASSUME);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      mode_q <= strap_to_mode(strap);
    else if (decide)
      mode_q <= verdict;
  end

endmodule

// File: rtl/irq_route_matrix.sv
module irq_route_matrix
  import irq_autoroute_pkg::*;
#(
  parameter int NUM_SLOTS  = 4,
  parameter int FIRST_SLOT = 0
) (
  input  logic [NUM_SLOTS*PINS-1:0] int_lvl,
  input  logic                      alt_board,
  input  logic                      legacy,
  output logic [PINS-1:0]           irq_out
);

  localparam int TOTAL = NUM_SLOTS * PINS;

  logic [PINS-1:0] contrib [TOTAL];

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    localparam logic [1:0] SLOT_MOD = 2'((FIRST_SLOT + s) % 4);
    for (genvar p = 0; p < PINS; p++) begin : g_pin
      logic [1:0] dst;
      assign dst = route_idx(SLOT_MOD, 2'(p), alt_board, legacy);
      assign contrib[s*PINS+p] = int_lvl[s*PINS+p] ? (PINS'(1) << dst) : '0;
    end
  end

  always_comb begin
    irq_out = '0;
    for (int k = 0; k < TOTAL; k++)
      irq_out = irq_out | contrib[k];
  end

endmodule

// File: rtl/irq_autoroute.sv
module irq_autoroute
  import irq_autoroute_pkg::*;
#(
  parameter int                NUM_SLOTS   = 4,
  parameter int                FIRST_SLOT  = 0,
  parameter int                ADDR_W      = 24,
  parameter logic [7:0]        LINE_OFS    = 8'h3C,
  parameter logic [LINE_W-1:0] LEGACY_BASE = 8'd27,
  parameter logic [LINE_W-1:0] HI_OFS      = 8'd64
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_SLOTS*PINS-1:0] int_lvl,
  input  logic                      cfg_wr,
  input  logic [ADDR_W-1:0]         cfg_addr,
  input  logic [LINE_W-1:0]         cfg_wdata,
  input  logic                      alt_board,
  input  logic [1:0]                mode_strap,
  output logic [PINS-1:0]           irq_out,
  output logic [1:0]                mode
);

  logic        snoop_hit;
  logic        mode_decide;
  route_mode_e snoop_verdict;
  route_mode_e mode_q;

  irq_line_snoop #(
    .ADDR_W(ADDR_W), .LINE_OFS(LINE_OFS),
    .LEGACY_BASE(LEGACY_BASE), .HI_OFS(HI_OFS)
  ) u_snoop (
    .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .alt_board(alt_board), .hit(snoop_hit), .verdict(snoop_verdict)
  );

  irq_mode_reg u_mode (
    .clk(clk), .rst_n(rst_n), .strap(mode_strap), .hit(snoop_hit),
    .verdict(snoop_verdict), .mode_q(mode_q), .decide(mode_decide)
  );

  irq_route_matrix #(.NUM_SLOTS(NUM_SLOTS), .FIRST_SLOT(FIRST_SLOT)) u_matrix (
    .int_lvl(int_lvl), .alt_board(alt_board),
    .legacy(mode_q == MODE_BROKEN), .irq_out(irq_out)
  );

  assign mode = mode_q;

endmodule

// File: rtl/irq_autoroute_chk.sv
module irq_autoroute_chk #(
  parameter int         NUM_SLOTS   = 4,
  parameter logic [7:0] LINE_OFS    = 8'h3C,
  parameter logic [7:0] LEGACY_BASE = 8'd27,
  parameter logic [7:0] HI_OFS      = 8'd64
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [NUM_SLOTS*4-1:0] int_lvl,
  input logic                   cfg_wr,
  input logic [7:0]             addr_lo,
  input logic [7:0]             cfg_wdata,
  input logic                   alt_board,
  input logic                   snoop_hit,
  input logic [1:0]             mode,
  input logic [3:0]             irq_out
);

  logic [3:0] pin_col;
  logic       in_lo;
  logic       in_hi;

  always_comb begin
    pin_col = '0;
    for (int s = 0; s < NUM_SLOTS; s++)
      pin_col = pin_col | int_lvl[s*4 +: 4];
  end

  assign in_lo = (cfg_wdata >= LEGACY_BASE) && (cfg_wdata <= LEGACY_BASE + 8'd3);
  assign in_hi = (cfg_wdata >= LEGACY_BASE + HI_OFS) &&
                 (cfg_wdata <= LEGACY_BASE + HI_OFS + 8'd3);

  // R1
  legal_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode != 2'd3);

  // R2
  sticky_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != 2'd0) |=> $stable(mode));

  // R3
  ignored_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && (addr_lo != LINE_OFS || alt_board)) |=> $stable(mode));

  // R7
  foreign_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (snoop_hit && mode == 2'd0 && !in_lo && !in_hi) |=> (mode == 2'd2));

  // R8
  legacy_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd1) |-> (irq_out == pin_col));

endmodule

bind irq_autoroute irq_autoroute_chk #(
  .NUM_SLOTS(NUM_SLOTS), .LINE_OFS(LINE_OFS),
  .LEGACY_BASE(LEGACY_BASE), .HI_OFS(HI_OFS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .int_lvl(int_lvl), .cfg_wr(cfg_wr),
  .addr_lo(cfg_addr[7:0]), .cfg_wdata(cfg_wdata), .alt_board(alt_board),
  .snoop_hit(snoop_hit), .mode(mode), .irq_out(irq_out)
);

// File: tb/irq_autoroute_test.sv
`timescale 1ns/1ps
module irq_autoroute_test;

  localparam int M_UND = 0;
  localparam int M_LEG = 1;
  localparam int M_FIX = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] int_lvl = '0;
  logic        cfg_wr = 1'b0;
  logic [23:0] cfg_addr = '0;
  logic [7:0]  cfg_wdata = '0;
  logic        alt_board = 1'b0;
  logic [1:0]  mode_strap = 2'd0;
  logic [3:0]  irq_out;
  logic [1:0]  mode;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  irq_autoroute uut (
    .clk(clk), .rst_n(rst_n), .int_lvl(int_lvl), .cfg_wr(cfg_wr),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .alt_board(alt_board),
    .mode_strap(mode_strap), .irq_out(irq_out), .mode(mode)
  );

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Expected lines, built by walking each active pin and stepping its line.
  function automatic logic [3:0] exp_lines(input logic [15:0] lv, input int m,
                                           input logic alt);
    logic [3:0] r = '0;
    for (int s = 0; s < 4; s++)
      for (int p = 0; p < 4; p++)
        if (lv[s*4+p]) begin
          int line = p;
          if (m != M_LEG) line = (p + s + (alt ? 3 : 2)) % 4;
          r[line] = 1'b1;
        end
    return r;
  endfunction

  function automatic logic [23:0] line_addr(input int dev);
    return {8'h00, 5'(dev), 3'b000, 8'h3C};
  endfunction

  task automatic do_reset(input logic [1:0] strap, input logic alt);
    @(negedge clk);
    rst_n = 1'b0; mode_strap = strap; alt_board = alt; cfg_wr = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic cfg_write(input logic [23:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic t_reset();
    do_reset(2'd0, 1'b0); check("R1 strap0", mode, M_UND);
    do_reset(2'd1, 1'b0); check("R1 strap1", mode, M_LEG);
    do_reset(2'd2, 1'b0); check("R1 strap2", mode, M_FIX);
    do_reset(2'd3, 1'b0); check("R1 strap3", mode, M_UND);
  endtask

  task automatic t_ignored();
    do_reset(2'd0, 1'b0);
    cfg_write({8'h00, 5'd1, 3'b000, 8'h3D}, 8'd27);
    check("R3 other offset", mode, M_UND);
    @(negedge clk); cfg_wr = 1'b0; cfg_addr = line_addr(1); cfg_wdata = 8'd27;
    @(negedge clk);
    check("R3 no strobe", mode, M_UND);
    do_reset(2'd0, 1'b1);
    cfg_write(line_addr(1), 8'd27);
    check("R3 alt board", mode, M_UND);
  endtask

  task automatic t_base_value();
    do_reset(2'd0, 1'b0);
    cfg_write(line_addr(2), 8'd27);
    check("R5 slot2 keeps", mode, M_UND);
    cfg_write(line_addr(6), 8'd27);
    check("R4 dev6 is slot2", mode, M_UND);
    cfg_write(line_addr(1), 8'd27);
    check("R5 slot1 legacy", mode, M_LEG);
    do_reset(2'd0, 1'b0);
    cfg_write(line_addr(3), 8'd27);
    check("R5 slot3 legacy", mode, M_LEG);
  endtask

  task automatic t_shifted();
    do_reset(2'd0, 1'b0);
    cfg_write(line_addr(3), 8'd30);
    check("R6 slot+27", mode, M_LEG);
    do_reset(2'd0, 1'b0);
    cfg_write(line_addr(1), 8'd92);
    check("R6 slot+91", mode, M_LEG);
    do_reset(2'd0, 1'b0);
    cfg_write(line_addr(5), 8'd28);
    check("R4 dev5 is slot1", mode, M_LEG);
    do_reset(2'd0, 1'b0);
    cfg_write(line_addr(1), 8'd30);
    check("R7 wrong slot value", mode, M_FIX);
  endtask

  task automatic t_sticky();
    do_reset(2'd0, 1'b0);
    cfg_write(line_addr(0), 8'd100);
    check("R7 fixed", mode, M_FIX);
    cfg_write(line_addr(1), 8'd27);
    check("R2 fixed stays", mode, M_FIX);
    do_reset(2'd0, 1'b0);
    cfg_write(line_addr(0), 8'd91);
    check("R6 slot0 hi", mode, M_LEG);
    cfg_write(line_addr(0), 8'd100);
    check("R2 legacy stays", mode, M_LEG);
  endtask

  task automatic t_timing();
    do_reset(2'd0, 1'b0);
    @(negedge clk);
    int_lvl = 16'h0001;
    cfg_wr = 1'b1; cfg_addr = line_addr(1); cfg_wdata = 8'd27;
    #1;
    check("R11 before edge", irq_out, 4'b0100);
    @(negedge clk);
    cfg_wr = 1'b0;
    check("R11 after edge", irq_out, 4'b0001);
    check("R11 mode", mode, M_LEG);
    int_lvl = '0;
  endtask

  task automatic t_route();
    for (int v = 0; v < 3; v++) begin
      logic alt = (v == 2);
      int m = (v == 0) ? M_LEG : M_UND;
      do_reset((v == 0) ? 2'd1 : 2'd0, alt);
      for (int b = 0; b < 16; b++) begin
        @(negedge clk);
        int_lvl = 16'(1) << b;
        #1;
        check((v == 0) ? "R8 single pin" : "R9 single pin",
              irq_out, exp_lines(int_lvl, m, alt));
      end
      @(negedge clk); int_lvl = 16'h0011; #1;
      check("R10 two pins", irq_out, exp_lines(16'h0011, m, alt));
      @(negedge clk); int_lvl = 16'h8421; #1;
      check("R10 diagonal", irq_out, exp_lines(16'h8421, m, alt));
      @(negedge clk); int_lvl = 16'h0000; #1;
      check("R10 idle", irq_out, 0);
    end
    do_reset(2'd2, 1'b0);
    @(negedge clk); int_lvl = 16'h0011; #1;
    check("R9 fixed mode", irq_out, 4'b1100);
    @(negedge clk); int_lvl = '0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_ignored();
    t_base_value();
    t_shifted();
    t_sticky();
    t_timing();
    t_route();
    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule